// File: doc/BRIEF.md
# Four-Lane Double-Data-Rate Sample Serializer

This block takes one 12-bit code per channel for four channels, once per sample period, and sends each code out on its own one-bit serial lane. Next to the lanes it drives a forwarded bit clock and a frame strobe. Both edges of the bit clock carry data, so the bit clock runs at six times the sample rate while twelve bits leave each lane per period. The frame strobe runs at the sample rate with a 50% duty cycle, and its rising edge marks the first bit of every word.

The whole block runs in one fast clock domain at twelve times the sample rate. It builds its own sample-period timing and raises a one-cycle capture strobe so that the upstream logic knows when its inputs are taken. Each input is a signed two's-complement offset from mid-scale. The block converts it to an unsigned code and saturates it at both ends. The captured words pass through a fixed pipeline delay of whole sample periods before they are serialized. A power-down input empties that pipeline and silences the lanes. A data-valid flag shows which words on the lanes hold real samples.

Top module: `quad_ddr_serializer`

## Requirements
- R1: While `rst` is high, the lanes and `dvalid` read 0, `smp_strobe` reads 0, and `frame` and `bit_clk` both read 1.
- R2: `smp_strobe` is high for exactly one cycle in every 12. `raw_in` and `pd` are captured at the clock edge that ends that cycle.
- R3: `frame` rises in the cycle after `smp_strobe`. It then stays high for 6 cycles and low for 6 cycles.
- R4: `bit_clk` changes level every cycle and is high in the cycle in which `frame` rises, giving 6 bit-clock periods per word.
- R5: Each lane sends its 12-bit code most significant bit first. Bit 11 is on the lane in the cycle in which `frame` rises, and bit 0 is on the lane in the following `smp_strobe` cycle.
- R6: A word captured at a capture edge starts on the lanes in the cycle that begins LATENCY sample periods (9 by default, 108 clock cycles) after that edge.
- R7: The code equals the signed input plus 2048. Results below 0 give 0 and results above 4095 give 4095, so -2048 maps to 0, 0 maps to 2048 and 2047 maps to 4095.
- R8: Lane i carries the code of `raw_in[i*RAW_W +: RAW_W]` and is independent of the other lanes.
- R9: From the first clock edge at which `pd` is high, all lanes and `dvalid` read 0. A word that is in the pipeline at such an edge, or that is captured while `pd` is high, never appears on the lanes.
- R10: `dvalid` is high for the whole of each word that was captured with `pd` low and not discarded, and low otherwise. After `pd` is released, it first rises with the word captured at the first capture edge with `pd` low. It changes only where `frame` rises, except that it drops at once when `pd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twelve times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| pd | input | 1 | Power-down; while high, the pipeline is emptied and the lanes are held at 0 |
| raw_in | input | 4*RAW_W | Signed per-channel input values, channel i in bits [i*RAW_W +: RAW_W] |
| smp_strobe | output | 1 | High in the cycle whose closing edge captures `raw_in` |
| lane_out | output | 4 | Serial data, one bit per channel |
| bit_clk | output | 1 | Forwarded bit clock; every edge starts a new bit |
| frame | output | 1 | Sample-rate frame strobe; its rising edge marks bit 11 |
| dvalid | output | 1 | High while the current words on the lanes hold real samples |

## Verification
The serial words are tried with saturating and in-range values, with alternating-bit codes, and with a single one-bit walking through every position on differently rotated lanes. Together these separate a wrong bit order, a lane swap and an off-by-one in the mid-scale offset or the clipping limits. Every word received from every lane is compared with the word that was captured exactly LATENCY periods earlier, so a pipeline that is one stage too short or too long fails on every word. Power-down is asserted in the middle of a stream of valid words, which shows whether the words still in flight are discarded. The frame-by-frame count of `dvalid` after release pins down when the first real word comes back.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int LANES         = 4;
    localparam int CODE_W        = 12;
    localparam int SLOTS_PER_SMP = CODE_W;
    localparam int HALF_SLOTS    = SLOTS_PER_SMP / 2;
    localparam int PH_W          = $clog2(SLOTS_PER_SMP);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [PH_W-1:0]   phase_t;

    localparam code_t  CODE_TOP = '1;
    localparam code_t  CODE_MID = code_t'(1) << (CODE_W - 1);
    localparam phase_t PH_LAST  = phase_t'(SLOTS_PER_SMP - 1);

    // One sample period worth of data moving through the delay line
    typedef struct packed {
        logic                  vld;
        code_t [LANES-1:0]     code;
    } smp_word_t;

    typedef enum logic [1:0] {
        CLIP_NONE = 2'd0,
        CLIP_LOW  = 2'd1,
        CLIP_HIGH = 2'd2
    } clip_e;

    function automatic logic phase_in_high_half(input phase_t ph);
        return ph < phase_t'(HALF_SLOTS);
    endfunction

endpackage

// File: rtl/ser_phase_gen.sv
module ser_phase_gen
    import ser_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic strobe,
    output logic frame,
    output logic bclk
);

    phase_t ph_q;
    phase_t ph_d;
    logic   frame_q;
    logic   bclk_q;

    always_comb begin
        if (ph_q == PH_LAST) ph_d = '0;
        else                 ph_d = ph_q + 1'b1;
    end

    // Frame and bit clock are registered from the next phase so they line
    // up with the phase register and carry no decode glitches.
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= '0;
            frame_q <= 1'b1;
            bclk_q  <= 1'b1;
        end else begin
            ph_q    <= ph_d;
            frame_q <= phase_in_high_half(ph_d);
            bclk_q  <= ~ph_d[0];
        end
    end

    assign strobe = (ph_q == PH_LAST);
    assign frame  = frame_q;
    assign bclk   = bclk_q;

endmodule

// File: rtl/ser_clip.sv
module ser_clip
    import ser_pkg::*;
#(
    parameter int RAW_W = 14
) (
    input  logic [RAW_W-1:0] raw,
    output code_t            code
);

    localparam int EXT_W = (RAW_W > CODE_W) ? RAW_W + 1 : CODE_W + 2;

    logic [EXT_W-1:0] raw_ext;
    logic [EXT_W-1:0] sum;
    clip_e            kind;

    assign raw_ext = {{(EXT_W - RAW_W){raw[RAW_W-1]}}, raw};
    assign sum     = raw_ext + EXT_W'(CODE_MID);

    always_comb begin
        if (sum[EXT_W-1])                      kind = CLIP_LOW;
        else if (sum[EXT_W-2:CODE_W] != '0)    kind = CLIP_HIGH;
        else                                   kind = CLIP_NONE;
    end

    always_comb begin
        unique case (kind)
            CLIP_LOW:  code = '0;
            CLIP_HIGH: code = CODE_TOP;
            default:   code = sum[CODE_W-1:0];
        endcase
    end

endmodule

// File: rtl/ser_delay_line.sv
module ser_delay_line
    import ser_pkg::*;
#(
    parameter int DEPTH = 9
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      advance,
    input  smp_word_t din,
    output smp_word_t dout
);

    generate
        if (DEPTH == 1) begin : g_single
            smp_word_t st;
            always_ff @(posedge clk) begin
                if (rst || flush)  st <= '0;
                else if (advance)  st <= din;
            end
            assign dout = st;
        end else begin : g_chain
            smp_word_t [DEPTH-1:0] st;
            always_ff @(posedge clk) begin
                if (rst || flush)  st <= '0;
                else if (advance)  st <= {st[DEPTH-2:0], din};
            end
            assign dout = st[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/ser_lane_shift.sv
module ser_lane_shift
    import ser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  load,
    input  code_t din,
    output logic  sdo
);

    code_t sh;

    always_ff @(posedge clk) begin
        if (rst || flush) sh <= '0;
        else if (load)    sh <= din;
        else              sh <= {sh[CODE_W-2:0], 1'b0};
    end

    assign sdo = sh[CODE_W-1];

endmodule

// File: rtl/quad_ddr_serializer.sv
module quad_ddr_serializer
    import ser_pkg::*;
#(
    parameter int RAW_W   = 14,
    parameter int LATENCY = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pd,
    input  logic [LANES*RAW_W-1:0] raw_in,
    output logic                   smp_strobe,
    output logic [LANES-1:0]       lane_out,
    output logic                   bit_clk,
    output logic                   frame,
    output logic                   dvalid
);

    logic              strobe;
    code_t [LANES-1:0] clip_code;
    smp_word_t         cap_word;
    smp_word_t         tail_word;
    logic              dvalid_q;

    ser_phase_gen u_phase (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .frame  (frame),
        .bclk   (bit_clk)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_clip
            ser_clip #(.RAW_W(RAW_W)) u_clip (
                .raw  (raw_in[i*RAW_W +: RAW_W]),
                .code (clip_code[i])
            );
        end
    endgenerate

    assign cap_word = {~pd, clip_code};

    ser_delay_line #(.DEPTH(LATENCY)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .flush   (pd),
        .advance (strobe),
        .din     (cap_word),
        .dout    (tail_word)
    );

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            ser_lane_shift u_shift (
                .clk   (clk),
                .rst   (rst),
                .flush (pd),
                .load  (strobe),
                .din   (tail_word.code[i]),
                .sdo   (lane_out[i])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || pd)   dvalid_q <= 1'b0;
        else if (strobe) dvalid_q <= tail_word.vld;
    end

    assign dvalid     = dvalid_q;
    assign smp_strobe = strobe;

endmodule

// File: rtl/quad_ddr_serializer_chk.sv
module quad_ddr_serializer_chk
    import ser_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             pd,
    input logic             smp_strobe,
    input logic [LANES-1:0] lane_out,
    input logic             bit_clk,
    input logic             frame,
    input logic             dvalid
);

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        smp_strobe |=> !smp_strobe);

    // R3
    frame_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        smp_strobe |=> $rose(frame));

    // R4
    bclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (bit_clk != $past(bit_clk)));

    // R4
    bclk_high_at_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame) |-> bit_clk);

    // R9
    pd_silence_chk: assert property (@(posedge clk) disable iff (rst)
        $past(pd) |-> (lane_out == '0 && !dvalid));

    // R10
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dvalid) |-> $rose(frame));

    // R10
    valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dvalid) |-> ($past(pd) || $rose(frame)));

endmodule

bind quad_ddr_serializer quad_ddr_serializer_chk u_chk (.*);

// File: tb/quad_ddr_serializer_test.sv
module quad_ddr_serializer_test;
    import ser_pkg::*;

    localparam int RW    = 14;
    localparam int LAT   = 9;
    localparam int NSLOT = 512;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                pd  = 1'b0;
    logic [LANES*RW-1:0] raw_in = '0;
    logic                smp_strobe;
    logic [LANES-1:0]    lane_out;
    logic                bit_clk;
    logic                frame;
    logic                dvalid;

    quad_ddr_serializer #(.RAW_W(RW), .LATENCY(LAT)) uut (.*);

    always #5 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    code_t exp_code [NSLOT][LANES];
    bit    exp_v [NSLOT];
    int    slot = 0;
    int    nbits = 0;
    logic  prev_frame = 1'b1;
    code_t rx [LANES];
    int    nxt_raw [LANES];
    bit    nxt_pd = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic code_t ref_code(input int v);
        if (v < -2048) return '0;
        if (v > 2047)  return code_t'(4095);
        return code_t'(v + 2048);
    endfunction

    // Monitor and stimulus applier share one process on the falling edge.
    always @(negedge clk) begin
        if (rst) begin
            prev_frame = 1'b1;
            nbits      = 0;
        end else begin
            if (frame && !prev_frame) begin
                slot  = slot + 1;
                nbits = 0;
            end
            prev_frame = frame;
            for (int l = 0; l < LANES; l++) rx[l] = {rx[l][CODE_W-2:0], lane_out[l]};
            nbits++;
            if (smp_strobe && nbits == CODE_W && slot < NSLOT) begin
                for (int l = 0; l < LANES; l++)
                    check(rx[l] == exp_code[slot][l],
                          $sformatf("R5 R6 R7 R8 word lane %0d slot %0d", l, slot),
                          int'(rx[l]), int'(exp_code[slot][l]));
                check(dvalid == exp_v[slot], $sformatf("R10 dvalid slot %0d", slot),
                      int'(dvalid), int'(exp_v[slot]));
            end
            if (smp_strobe) begin
                pd = nxt_pd;
                for (int l = 0; l < LANES; l++) raw_in[l*RW +: RW] = RW'(nxt_raw[l]);
                if (nxt_pd) begin
                    for (int j = 1; j <= LAT + 1; j++)
                        if (slot + j < NSLOT) begin
                            exp_v[slot+j] = 1'b0;
                            for (int l = 0; l < LANES; l++) exp_code[slot+j][l] = '0;
                        end
                end else if (slot + LAT + 1 < NSLOT) begin
                    exp_v[slot+LAT+1] = 1'b1;
                    for (int l = 0; l < LANES; l++) exp_code[slot+LAT+1][l] = ref_code(nxt_raw[l]);
                end
            end
        end
    end

    // Values are taken at the second capture edge after the call.
    task automatic set_slot(input int a, input int b, input int c, input int d, input bit p);
        do @(negedge clk); while (!smp_strobe);
        #2;
        nxt_raw[0] = a; nxt_raw[1] = b; nxt_raw[2] = c; nxt_raw[3] = d;
        nxt_pd = p;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(lane_out == '0, "R1 lanes in reset", int'(lane_out), 0);
        check(dvalid == 1'b0, "R1 dvalid in reset", int'(dvalid), 0);
        check(smp_strobe == 1'b0, "R1 strobe in reset", int'(smp_strobe), 0);
        check(frame == 1'b1, "R1 frame in reset", int'(frame), 1);
        check(bit_clk == 1'b1, "R1 bit_clk in reset", int'(bit_clk), 1);
        rst = 1'b0;
    endtask

    task automatic t_framing();
        do @(negedge clk); while (!smp_strobe);
        for (int k = 0; k < 2 * SLOTS_PER_SMP; k++) begin
            @(negedge clk);
            check(frame == ((k % 12) < 6), $sformatf("R3 frame at offset %0d", k),
                  int'(frame), int'((k % 12) < 6));
            check(bit_clk == ((k % 2) == 0), $sformatf("R4 bit_clk at offset %0d", k),
                  int'(bit_clk), int'((k % 2) == 0));
            check(smp_strobe == ((k % 12) == 11), $sformatf("R2 strobe at offset %0d", k),
                  int'(smp_strobe), int'((k % 12) == 11));
        end
    endtask

    task automatic t_clip();
        // R7: both saturation limits, exact ends and mid-scale
        set_slot(-2048, -3000, -8192, 0, 1'b0);
        set_slot(2047, 2048, 8191, 5, 1'b0);
        set_slot(-1, 1, -2047, 2046, 1'b0);
    endtask

    task automatic t_patterns();
        // R5 R8: alternating bits and a walking one, rotated per lane
        set_slot(2730 - 2048, 1365 - 2048, 2730 - 2048, 1365 - 2048, 1'b0);
        set_slot(1365 - 2048, 2730 - 2048, 1365 - 2048, 2730 - 2048, 1'b0);
        for (int k = 0; k < CODE_W; k++)
            set_slot((1 << k) - 2048, (1 << ((k + 3) % 12)) - 2048,
                     (1 << ((k + 6) % 12)) - 2048, (1 << ((k + 9) % 12)) - 2048, 1'b0);
    endtask

    task automatic t_powerdown();
        set_slot(100, -200, 300, -400, 1'b0);
        set_slot(111, 222, 333, 444, 1'b1);
        set_slot(555, 666, 777, 888, 1'b1);
        // R9: pd is in force now; lanes and dvalid must stay at 0
        for (int k = 0; k < SLOTS_PER_SMP; k++) begin
            @(negedge clk);
            check(lane_out == '0, "R9 lanes during pd", int'(lane_out), 0);
            check(dvalid == 1'b0, "R9 dvalid during pd", int'(dvalid), 0);
        end
        set_slot(7, -7, 70, -70, 1'b0);
        // R10: count frames from the first capture with pd low
        do @(negedge clk); while (!smp_strobe);
        for (int w = 1; w <= LAT + 1; w++) begin
            repeat (w == 1 ? 1 : SLOTS_PER_SMP) @(negedge clk);
            check(dvalid == (w == LAT + 1), $sformatf("R10 dvalid at frame %0d after release", w),
                  int'(dvalid), int'(w == LAT + 1));
        end
    endtask

    task automatic t_drain();
        set_slot(-5, 5, -50, 50, 1'b0);
        repeat ((LAT + 3) * SLOTS_PER_SMP) @(negedge clk);
    endtask

    initial begin
        for (int s = 0; s < NSLOT; s++) begin
            exp_v[s] = 1'b0;
            for (int l = 0; l < LANES; l++) exp_code[s][l] = '0;
        end
        for (int l = 0; l < LANES; l++) nxt_raw[l] = 0;
        t_reset();
        t_framing();
        t_clip();
        t_patterns();
        t_powerdown();
        t_drain();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule